// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block watches a single asynchronous interrupt pin. The pin is brought into the system clock domain, and a sampled majority-free filter then strips short glitches from it. The filter's output level is allowed to change only after several consecutive samples agree on the new value. When the filtered level changes in the way the configured edge condition asks for, the block emits a one-cycle request pulse. An interrupt controller outside the block consumes that pulse.

A small 8-bit control register holds two settings. The first is the edge condition: rising, falling, both, or none. The second is the filter sampling interval, which is the system clock divided by 1, 4, 8 or 16. The same register shows the current filtered level as a read-only bit. A mode input selects slow operation. In slow operation the filter samples once every few ticks of a low-frequency clock-enable, and the interval field is ignored. Software masks the request while it rewrites the register or switches mode, so the block does not suppress requests that such changes might cause.

Top module: `xirq_filter_edge`

## Requirements
- R1: After reset the request output is low and the control register reads 0x00.
- R2: Register layout: bits 1:0 are the sampling interval, bits 3:2 are the edge condition, and bit 4 is the read-only filtered level. Bits 7:5 always read 0. Writes to bits 7:4 have no effect. A write takes effect on the next clock edge.
- R3: Edge code 00 requests on a low-to-high change of the filtered level.
- R4: Edge code 01 requests on a high-to-low change of the filtered level.
- R5: Edge code 10 requests on every change of the filtered level.
- R6: Edge code 11 never produces a request, even when the filtered level changes.
- R7: Register bit 4 equals the filtered level, which starts at 0 after reset.
- R8: The pin passes through a two-flop synchronizer. The filtered level takes a new value only after AGREE_CNT consecutive samples (default 3) all hold that value. A sample equal to the current level clears the count, so bursts covering fewer samples are rejected.
- R9: In normal mode (slow_mode_i = 0), interval codes 00, 01, 10 and 11 take a sample every 1, 4, 8 and 16 system clocks respectively.
- R10: In slow mode (slow_mode_i = 1), a sample is taken once every LF_DIV pulses of lf_tick_i (default 4), whatever the interval field holds.
- R11: The request is a pulse one system clock wide. It rises on the clock edge after the one on which the filtered level changed.
- R12: A pin held high through reset yields exactly one rising change of the filtered level, and therefore one request under code 00, once the filter settles.
- R13: A change of the interval field or of the mode input restarts the sampling divider on the following clock. The first sample then comes one full new interval after that restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous interrupt pin |
| slow_mode_i | input | 1 | 1 selects the low-frequency sampling rate |
| lf_tick_i | input | 1 | One-cycle enable per low-frequency clock period |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register read data |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, three agreeing samples, and a low-frequency divide of four. It drives lf_tick_i once every five clocks, which gives a slow-mode interval of twenty clocks. With the normal-mode setting of one sample per clock, the latency is exact, so several checks can land on a single cycle. At the divide-by-16 setting, a four-clock pulse reaches at most one sample, so the divider's effect on rejection can be observed. Switching from divide-by-8 to divide-by-16 at a known cycle makes the divider restart visible as one exact request cycle.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic [1:0] edge_sel;
        logic [1:0] rate_sel;
    } cfg_t;

    localparam int unsigned MAX_FAST_DIV = 16;

    function automatic int unsigned rate_period(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return MAX_FAST_DIV;
        endcase
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.sh[STAGES-1];

endmodule

// File: rtl/xirq_rate_gen.sv
module xirq_rate_gen
    import xirq_pkg::*;
#(
    parameter int LF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel_i,
    input  logic       slow_i,
    input  logic       lf_tick_i,
    output logic       tick_o
);
    localparam int unsigned MAXP = (LF_DIV > int'(MAX_FAST_DIV)) ? LF_DIV : MAX_FAST_DIV;
    localparam int CNT_W = $clog2(MAXP + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       rate_prev;
        logic             slow_prev;
    } rate_st_t;

    rate_st_t    st_d, st_q;
    logic        changed;
    logic        step;
    int unsigned period;

    always_comb begin
        st_d           = st_q;
        tick_o         = 1'b0;
        changed        = (rate_sel_i != st_q.rate_prev) || (slow_i != st_q.slow_prev);
        period         = slow_i ? LF_DIV : rate_period(rate_sel_i);
        step           = slow_i ? lf_tick_i : 1'b1;
        st_d.rate_prev = rate_sel_i;
        st_d.slow_prev = slow_i;
        if (changed) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == CNT_W'(period - 1)) begin
                tick_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SLOW_NEEDS_LF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_i && !lf_tick_i) |-> !tick_o); // R10

    AST_RESTART_ON_RATE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rate_sel_i != $past(rate_sel_i)) || (slow_i != $past(slow_i))) |-> !tick_o); // R13

endmodule

// File: rtl/xirq_glitch_filter.sv
module xirq_glitch_filter #(
    parameter int AGREE_CNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic din_i,
    output logic level_o
);
    localparam int AW = $clog2(AGREE_CNT + 1);

    typedef struct packed {
        logic          level;
        logic [AW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_i) begin
            if (din_i == st_q.level) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == AW'(AGREE_CNT - 1)) begin
                st_d.level = din_i;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

    AST_LEVEL_MOVES_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != $past(level_o)) |-> $past(sample_i)); // R8

    AST_LEVEL_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != $past(level_o)) |-> (level_o == $past(din_i))); // R8

endmodule

// File: rtl/xirq_edge_det.sv
module xirq_edge_det
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic [1:0] edge_sel_i,
    output logic       irq_o
);
    typedef struct packed {
        logic prev;
        logic irq;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise;
    logic     fall;

    always_comb begin
        st_d      = st_q;
        rise      = level_i & ~st_q.prev;
        fall      = ~level_i & st_q.prev;
        st_d.prev = level_i;
        case (edge_sel_e'(edge_sel_i))
            EDGE_RISE: st_d.irq = rise;
            EDGE_FALL: st_d.irq = fall;
            EDGE_BOTH: st_d.irq = rise | fall;
            default:   st_d.irq = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R11

    AST_IRQ_FOLLOWS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(level_i) != $past(level_i, 2))); // R11

    AST_NO_IRQ_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(edge_sel_i) != 2'b11)); // R6

endmodule

// File: rtl/xirq_filter_edge.sv
module xirq_filter_edge
    import xirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AGREE_CNT   = 3,
    parameter int LF_DIV      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       slow_mode_i,
    input  logic       lf_tick_i,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    output logic       irq_o
);
    typedef struct packed {
        cfg_t cfg;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    pin_sync;
    logic    sample_en;
    logic    level;
    logic    unused_hi;

    assign unused_hi = ^cfg_wdata_i[7:4];

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d.cfg.edge_sel = cfg_wdata_i[3:2];
            st_d.cfg.rate_sel = cfg_wdata_i[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata_o = {3'b000, level, st_q.cfg.edge_sel, st_q.cfg.rate_sel};

    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    xirq_rate_gen #(.LF_DIV(LF_DIV)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (st_q.cfg.rate_sel),
        .slow_i     (slow_mode_i),
        .lf_tick_i  (lf_tick_i),
        .tick_o     (sample_en)
    );

    xirq_glitch_filter #(.AGREE_CNT(AGREE_CNT)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_en),
        .din_i    (pin_sync),
        .level_o  (level)
    );

    xirq_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (level),
        .edge_sel_i (st_q.cfg.edge_sel),
        .irq_o      (irq_o)
    );

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_rdata_o[3:0] == $past(cfg_wdata_i[3:0]))); // R2

endmodule

// File: tb/xirq_filter_edge_test.sv
module xirq_filter_edge_test;
    localparam int CLK_PERIOD = 10;
    localparam int LFP        = 5;
    localparam int LFDIV      = 4;

    typedef struct {
        int    lo;
        int    hi;
        logic  lvl;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b1;
    logic       slow = 1'b0;
    logic       lf_tick = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   pulses = 0;
    logic irq_prev = 1'b0;
    exp_t q[$];

    xirq_filter_edge uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .slow_mode_i (slow),
        .lf_tick_i   (lf_tick),
        .cfg_we_i    (we),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) lf_tick <= ((cyc % LFP) == 0);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic void push(input int c, input int n, input logic lvl, input string tag);
        exp_t e;
        e.lo = c + 4 + 2*n;
        e.hi = c + 3 + 3*n;
        e.lvl = lvl;
        e.tag = tag;
        q.push_back(e);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) begin
                pulses++;
                chk(!irq_prev, "R11 width", 1, 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R11 unexpected request", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc >= e.lo && cyc <= e.hi, e.tag, cyc, e.lo);
                    chk(rdata[4] == e.lvl, "R11 level at request", int'(rdata[4]), int'(e.lvl));
                end
            end
            irq_prev <= irq;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        we = 1'b1;
        wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic set_pin(input logic v, output int c);
        @(negedge clk);
        pin = v;
        c = cyc;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c;
        int w;
        int p;
        idle(4);
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        push(cyc, 1, 1'b1, "R12 rising after reset");
        rst_n = 1'b1;
        idle(20);
        chk(rdata[4] == 1'b1, "R7 level high", rdata[4], 1);

        write_cfg(8'hEF);
        chk(rdata == 8'h1F, "R2 readback", rdata, 8'h1F);
        write_cfg(8'h00);
        chk(rdata == 8'h10, "R2 readback zero", rdata, 8'h10);

        set_pin(1'b0, c);
        idle(20);
        chk(rdata[4] == 1'b0, "R7 level low", rdata[4], 0);
        set_pin(1'b1, c);
        push(c, 1, 1'b1, "R3 rising");
        idle(20);

        write_cfg(8'h04);
        set_pin(1'b0, c);
        push(c, 1, 1'b0, "R4 falling");
        idle(20);
        set_pin(1'b1, c);
        idle(20);

        write_cfg(8'h08);
        set_pin(1'b0, c);
        push(c, 1, 1'b0, "R5 both falling");
        idle(20);
        p = pulses;
        set_pin(1'b1, c);
        idle(1);
        set_pin(1'b0, c);
        idle(20);
        chk(rdata[4] == 1'b0, "R8 short burst level", rdata[4], 0);
        chk(pulses == p, "R8 short burst request", pulses - p, 0);
        set_pin(1'b1, c);
        push(c, 1, 1'b1, "R8 three samples rise");
        idle(2);
        set_pin(1'b0, c);
        push(c, 1, 1'b0, "R5 both second edge");
        idle(20);

        write_cfg(8'h0C);
        p = pulses;
        set_pin(1'b1, c);
        idle(20);
        chk(rdata[4] == 1'b1, "R7 level under reserved", rdata[4], 1);
        set_pin(1'b0, c);
        idle(20);
        chk(pulses == p, "R6 reserved no request", pulses - p, 0);

        for (int code = 1; code < 4; code++) begin
            int n;
            n = (code == 1) ? 4 : (code == 2) ? 8 : 16;
            write_cfg(8'(code));
            idle(7);
            set_pin(1'b1, c);
            push(c, n, 1'b1, "R9 divided rate");
            idle(3*n + 20);
            set_pin(1'b0, c);
            idle(3*n + 20);
        end

        p = pulses;
        set_pin(1'b1, c);
        idle(3);
        set_pin(1'b0, c);
        idle(80);
        chk(rdata[4] == 1'b0, "R9 div16 rejects short pulse", rdata[4], 0);
        chk(pulses == p, "R9 div16 no request", pulses - p, 0);

        write_cfg(8'h02);
        idle(37);
        @(negedge clk);
        we = 1'b1;
        wdata = 8'h03;
        pin = 1'b1;
        w = cyc;
        @(negedge clk);
        we = 1'b0;
        q.push_back('{w + 51, w + 51, 1'b1, "R13 restart timing"});
        idle(80);
        set_pin(1'b0, c);
        idle(80);

        write_cfg(8'h00);
        slow = 1'b1;
        idle(50);
        set_pin(1'b1, c);
        push(c, LFDIV*LFP, 1'b1, "R10 slow rate field 0");
        idle(100);
        write_cfg(8'h0B);
        idle(30);
        set_pin(1'b0, c);
        push(c, LFDIV*LFP, 1'b0, "R10 slow rate field 3");
        idle(100);
        slow = 1'b0;
        idle(20);

        chk(q.size() == 0, "R11 missing requests", q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule